// File: doc/BRIEF.md
# Serial Converter Output Sequencer

This block is the digital sequencer behind the serial port of a 12-bit sampling converter. A single control input, `conv`, starts a conversion when it rises. On that edge the block captures a parallel sample word, which stands in for the analog front end. Over the following clocks it sends the word out on a serial data line, one bit per clock, most significant bit first. The data line has a separate drive-enable output, so a pad or a bus model can tri-state it.

Dropping `conv` while a conversion is running ends the conversion early and sends the block to power-down. If `conv` drops during the last conversion clock, while the least significant bit is on the line, the block instead sends the same word a second time in reverse order, bit 1 up to bit 11, and then powers down. A two-bit status output and a low-power flag show which mode the sequencer is in.

Top module: `serial_conv_seq`

## Requirements
- R1: A new conversion starts on a clock where `conv` is sampled high after having been sampled low on the previous clock, in idle or power-down. The sample word is captured on that edge, and `status` reads 01 (converting) from the next cycle.
- R2: A conversion lasts 13 cycles. In cycle 1 the line is driven low. Cycles 2 to 13 carry bits 11 down to 0 of the captured word, one per cycle.
- R3: Changes on `sample_in` after the start edge have no effect on the bits shifted out for that conversion or for its replay.
- R4: If `conv` is sampled low in conversion cycles 1 to 12, the conversion ends on that edge and `status` reads 11 (power-down) from the next cycle.
- R5: While converting, `sdata_oe` follows `conv` in the same cycle, with no clock delay. In idle and power-down `sdata_oe` is 0, and `sdata` reads 0 whenever `sdata_oe` is 0.
- R6: If `conv` is sampled low in conversion cycle 13, `status` reads 10 (replay) for the next 11 cycles. During those cycles `sdata_oe` is 1 and bits 1 up to 11 of the word appear in that order. The block then enters power-down (11).
- R7: `conv` has no effect during a replay: its length and its data are the same whatever `conv` does.
- R8: If `conv` stays high through cycle 13, the block returns to idle (00).
- R9: Holding `conv` high in idle or power-down never starts a conversion. `conv` must first be sampled low for at least one clock.
- R10: `low_power` is 0 only while converting. It is 1 in idle, replay and power-down.
- R11: A synchronous active-high `rst` puts the block in idle with `sdata_oe` at 0. After reset, `conv` must be sampled low once before a conversion can start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| conv | input | 1 | Conversion control: rising edge starts, low aborts |
| sample_in | input | 12 | Parallel sample standing in for the analog input |
| sdata | output | 1 | Serial data bit |
| sdata_oe | output | 1 | Drive enable for the data line (0 = high impedance) |
| status | output | 2 | Mode: 00 idle, 01 converting, 10 replay, 11 power-down |
| low_power | output | 1 | Low-power mode indicator |

## Verification
The sequencer is exercised with asymmetric words, all-ones and all-zeros, and a single set MSB. Asymmetric words expose a swapped bit order. The uniform words separate real data from a line that is simply driven low. Aborts are placed in the first cycle, in the middle and in cycle 12, which tells a short-cycle apart from a replay. An abort in cycle 13 checks the replay order and its fixed length. During that replay `conv` is toggled, and `sample_in` is scrambled mid-conversion, to show that neither input has any effect. Restarts come straight out of power-down and after a held-high `conv`. A reset falls in the middle of a conversion.

// File: rtl/sco_pkg.sv
package sco_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_CONV   = 2'b01,
    ST_REPLAY = 2'b10,
    ST_SLEEP  = 2'b11
  } seq_state_t;
endpackage

// File: rtl/sco_ctrl.sv
module sco_ctrl
  import sco_pkg::*;
#(
  parameter int W  = 12,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          conv,
  output seq_state_t    state,
  output logic [CW-1:0] cnt,
  output logic          start_evt,
  output logic          abort_evt,
  output logic          replay_evt,
  output logic          done_evt,
  output logic          replay_end
);
  localparam logic [CW-1:0] LAST_CYC   = CW'(W + 1);
  localparam logic [CW-1:0] REPLAY_LEN = CW'(W - 1);

  logic conv_q;

  // named events for checking and for the datapath
  assign start_evt  = ((state == ST_IDLE) || (state == ST_SLEEP)) && conv && !conv_q;
  assign abort_evt  = (state == ST_CONV) && !conv && (cnt != LAST_CYC);
  assign replay_evt = (state == ST_CONV) && !conv && (cnt == LAST_CYC);
  assign done_evt   = (state == ST_CONV) && conv && (cnt == LAST_CYC);
  assign replay_end = (state == ST_REPLAY) && (cnt == REPLAY_LEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      conv_q <= 1'b1;
    end else begin
      conv_q <= conv;
      unique case (state)
        ST_IDLE, ST_SLEEP: begin
          if (start_evt) begin
            state <= ST_CONV;
            cnt   <= CW'(1);
          end
        end
        ST_CONV: begin
          if (abort_evt) begin
            state <= ST_SLEEP;
            cnt   <= '0;
          end else if (replay_evt) begin
            state <= ST_REPLAY;
            cnt   <= CW'(1);
          end else if (done_evt) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_REPLAY: begin
          if (replay_end) begin
            state <= ST_SLEEP;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ABORT_SLEEPS: assert property (@(posedge clk) disable iff (rst)
    abort_evt |=> (state == ST_SLEEP)) else $error("abort did not sleep"); // R4

  AST_LATE_ABORT_REPLAYS: assert property (@(posedge clk) disable iff (rst)
    replay_evt |=> (state == ST_REPLAY && cnt == CW'(1))) else $error("no replay"); // R6

  AST_REPLAY_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_REPLAY) |-> (cnt >= CW'(1) && cnt <= REPLAY_LEN)) else $error("replay length"); // R6

  AST_REPLAY_IGNORES_CONV: assert property (@(posedge clk) disable iff (rst)
    (state == ST_REPLAY && cnt != REPLAY_LEN) |=> (state == ST_REPLAY)) else $error("replay cut"); // R7

  AST_START_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CONV && cnt == CW'(1)) |-> ($past(conv) && !$past(conv, 2))) else $error("start w/o low"); // R9

  AST_DONE_IDLES: assert property (@(posedge clk) disable iff (rst)
    done_evt |=> (state == ST_IDLE)) else $error("done not idle"); // R8
endmodule

// File: rtl/sco_hold.sv
module sco_hold #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_evt,
  input  logic [W-1:0] sample_in,
  output logic [W-1:0] hold
);
  always_ff @(posedge clk) begin
    if (rst)            hold <= '0;
    else if (start_evt) hold <= sample_in;
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    !start_evt |=> $stable(hold)) else $error("hold changed"); // R3
endmodule

// File: rtl/sco_out.sv
module sco_out
  import sco_pkg::*;
#(
  parameter int W  = 12,
  parameter int CW = 4
) (
  input  seq_state_t    state,
  input  logic [CW-1:0] cnt,
  input  logic          conv,
  input  logic [W-1:0]  hold,
  output logic          sdata,
  output logic          sdata_oe
);
  // MSB-first: cycle 1 is a null bit, cycle k (2..W+1) carries bit W+1-k
  function automatic logic msb_bit(input logic [W-1:0] word, input logic [CW-1:0] k);
    int idx;
    idx = W + 1 - int'(k);
    if (idx < 0 || idx >= W) return 1'b0;
    return word[idx];
  endfunction

  // LSB-first replay: replay cycle k carries bit k
  function automatic logic lsb_bit(input logic [W-1:0] word, input logic [CW-1:0] k);
    if (int'(k) >= W) return 1'b0;
    return word[k];
  endfunction

  always_comb begin
    sdata_oe = 1'b0;
    sdata    = 1'b0;
    unique case (state)
      ST_CONV: begin
        sdata_oe = conv;
        sdata    = conv ? msb_bit(hold, cnt) : 1'b0;
      end
      ST_REPLAY: begin
        sdata_oe = 1'b1;
        sdata    = lsb_bit(hold, cnt);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/serial_conv_seq.sv
module serial_conv_seq
  import sco_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         conv,
  input  logic [W-1:0] sample_in,
  output logic         sdata,
  output logic         sdata_oe,
  output logic [1:0]   status,
  output logic         low_power
);
  localparam int CW = $clog2(W + 2);

  seq_state_t    state;
  logic [CW-1:0] cnt;
  logic          start_evt, abort_evt, replay_evt, done_evt, replay_end;
  logic [W-1:0]  hold;

  sco_ctrl #(.W(W), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .conv(conv), .state(state), .cnt(cnt),
    .start_evt(start_evt), .abort_evt(abort_evt), .replay_evt(replay_evt),
    .done_evt(done_evt), .replay_end(replay_end)
  );

  sco_hold #(.W(W)) u_hold (
    .clk(clk), .rst(rst), .start_evt(start_evt), .sample_in(sample_in), .hold(hold)
  );

  sco_out #(.W(W), .CW(CW)) u_out (
    .state(state), .cnt(cnt), .conv(conv), .hold(hold),
    .sdata(sdata), .sdata_oe(sdata_oe)
  );

  assign status    = state;
  assign low_power = (state != ST_CONV);

  AST_LOW_TRISTATES: assert property (@(posedge clk) disable iff (rst)
    (!conv && status == 2'b01) |-> !sdata_oe) else $error("line driven"); // R5

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !sdata_oe |-> !sdata) else $error("data without enable"); // R5

  AST_STARTS_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> (status == 2'b01 && !low_power)) else $error("no start"); // R1
endmodule

// File: tb/serial_conv_seq_test.sv
module serial_conv_seq_test;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         conv = 1'b1;
  logic [W-1:0] sample_in = '0;
  logic         sdata, sdata_oe, low_power;
  logic [1:0]   status;

  int tests = 0;
  int fails = 0;

  // reference model state
  int   mmode = 0;   // 0 idle, 1 conv, 2 replay, 3 sleep
  bit   mprev = 1'b1;
  bit   q[$];
  logic [W-1:0] mword = '0;

  always #2 clk = ~clk;

  serial_conv_seq #(.W(W)) uut (
    .clk(clk), .rst(rst), .conv(conv), .sample_in(sample_in),
    .sdata(sdata), .sdata_oe(sdata_oe), .status(status), .low_power(low_power)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive inputs, compare after settle, then advance model at the edge
  task automatic cyc(input bit c, input logic [W-1:0] s, input bit r = 1'b0);
    bit eoe, edat;
    conv = c; sample_in = s; rst = r;
    #1;
    eoe  = (mmode == 1) ? c : (mmode == 2);
    edat = eoe ? q[0] : 1'b0;
    chk(status == 2'(mmode), "R10 status", status, mmode);
    chk(low_power == (mmode != 1), "R10 low_power", low_power, (mmode != 1));
    chk(sdata_oe == eoe, "R5 enable", sdata_oe, eoe);
    chk(sdata == edat, (mmode == 2) ? "R6 replay bit" : "R2 serial bit", sdata, edat);
    @(posedge clk);
    if (r) begin
      mmode = 0; q.delete(); mprev = 1'b1;
    end else begin
      case (mmode)
        0, 3: if (c && !mprev) begin
          mword = s; q.delete(); q.push_back(1'b0);
          for (int i = W - 1; i >= 0; i--) q.push_back(s[i]);
          mmode = 1;
        end
        1: if (!c) begin
          if (q.size() == 1) begin
            q.delete();
            for (int i = 1; i < W; i++) q.push_back(mword[i]);
            mmode = 2;
          end else begin
            q.delete(); mmode = 3;
          end
        end else begin
          void'(q.pop_front());
          if (q.size() == 0) mmode = 0;
        end
        2: begin
          void'(q.pop_front());
          if (q.size() == 0) mmode = 3;
        end
        default: ;
      endcase
      mprev = c;
    end
    @(negedge clk);
  endtask

  // start then keep conv high for n more cycles, scrambling the sample input (R3)
  task automatic run_high(input logic [W-1:0] word, input int n);
    cyc(1'b1, word);
    for (int i = 0; i < n; i++) cyc(1'b1, word ^ W'(i * 37 + 5));
  endtask

  initial begin
    #(4 * 200000);
    fails++; tests++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R11: reset with conv held high; must stay idle afterwards (R9)
    cyc(1'b1, 12'h123, 1'b1);
    cyc(1'b1, 12'h123, 1'b1);
    for (int i = 0; i < 4; i++) cyc(1'b1, 12'h456);
    chk(status == 2'b00, "R11 idle after reset", status, 0);

    // R1 R2 R3 R8: full conversion, conv high throughout
    cyc(1'b0, 12'h000);
    run_high(12'hA5C, 13);
    chk(status == 2'b00, "R8 idle after full", status, 0);
    for (int i = 0; i < 3; i++) cyc(1'b1, 12'hFFF);   // R9 held high
    chk(status == 2'b00, "R9 no restart", status, 0);

    // R4: short-cycle in the middle, then restart from power-down
    cyc(1'b0, 12'h000);
    run_high(12'h3F1, 4);
    cyc(1'b0, 12'h3F1);
    chk(status == 2'b11, "R4 sleep after abort", status, 3);

    // R6 R7: abort in cycle 13 -> replay, conv toggled during replay
    run_high(12'h800, 12);
    cyc(1'b0, 12'h000);
    chk(status == 2'b10, "R6 replay entered", status, 2);
    for (int i = 0; i < 11; i++) cyc(1'(i % 2), 12'h0F0);
    chk(status == 2'b11, "R6 sleep after replay", status, 3);

    // replay with an asymmetric word
    cyc(1'b0, 12'h000);
    run_high(12'hC35, 12);
    for (int i = 0; i < 12; i++) cyc(1'b0, 12'hFFF);

    // R4 boundaries: abort in cycle 1 and cycle 12
    run_high(12'hFFF, 0);
    cyc(1'b0, 12'h000);
    chk(status == 2'b11, "R4 abort cycle 1", status, 3);
    run_high(12'h000, 11);
    cyc(1'b0, 12'h000);
    chk(status == 2'b11, "R4 abort cycle 12", status, 3);

    // all-ones full conversion, then reset in the middle of one (R11)
    cyc(1'b0, 12'h000);
    run_high(12'hFFF, 13);
    cyc(1'b0, 12'h000);
    run_high(12'h5A5, 6);
    cyc(1'b1, 12'h5A5, 1'b1);
    chk(status == 2'b00 && !sdata_oe, "R11 reset mid-run", status, 0);
    cyc(1'b1, 12'h5A5);
    cyc(1'b0, 12'h5A5);
    run_high(12'h5A5, 13);
    for (int i = 0; i < 3; i++) cyc(1'b0, 12'h000);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule